// File: doc/BRIEF.md
# Identification Page and Lock Controller

This block sits behind a serial-bus target engine. It serves the commands whose type identifier selects the auxiliary identification page instead of the main array. The page holds 128 bytes, and the low seven address bits pick a byte inside it. Address bit 10 of an incoming write decides what the write means. When the bit is clear, the write is a page write into the identification page. When the bit is set, the write is a lock request. A lock request takes effect only if the data byte carries a one in bit 1. Once the page is locked it stays read-only until a test reset clears it.

The engine sends the block already-decoded events, each one a single-cycle strobe: command start (with the type and direction), the two address bytes combined, each received write byte, and every Stop condition. The block answers each write byte with an acknowledge decision one cycle later. That answer is also how the lock status is read back. Software sends one data byte and then a new Start, and the answer tells it whether the page is locked. Write bytes are staged, and they reach the page only when a Stop follows a data byte directly. Reads come out as a valid/ready byte stream. `rd_valid` stays high for the whole read command. A byte counts as consumed only in a cycle where `rd_ready` is also high, and while `rd_ready` is low the engine may hold off for any number of cycles. The write side has no back-pressure, so each strobe is taken in the cycle it arrives.

Top module: `idp_lock_ctrl`

## Requirements
- R1: After test reset every page byte reads 8'hFF and the page is unlocked. After either reset, `rd_valid` and `wr_ack_valid` are low.
- R2: A write command for the identification page with address bit 10 = 0 stages its data bytes at consecutive offsets. The first offset is address bits 6..0, and all other address bits are ignored. The staged bytes reach the page only when a Stop arrives directly after a data byte.
- R3: Page-write offsets wrap from 127 back to 0 inside the page.
- R4: A new Start that arrives before the Stop discards every staged byte and any pending lock request. After a status query, Start then Stop changes nothing.
- R5: A Stop that does not directly follow a data byte commits nothing. An example is a Stop right after the address.
- R6: A write with address bit 10 = 1 sets the lock at its committing Stop, and only if bit 1 of the last data byte is 1. A byte with bit 1 = 0 leaves the page unlocked.
- R7: While the page is locked, page-write bytes leave the page unchanged.
- R8: Each data byte of an identification-page write produces `wr_ack_valid` exactly one cycle later. `wr_ack` is 1 when the page is unlocked and 0 when it is locked.
- R9: A read command for the identification page streams bytes starting at the current offset, with `rd_valid` held high. The offset advances only on a cycle where `rd_valid` and `rd_ready` are both high, wraps from 127 to 0, and `rd_data` stays stable while the engine stalls.
- R10: Commands whose type is not the identification page are ignored. They produce no acknowledge pulse, no read stream, no page change and no offset change.
- R11: The functional reset `rst_n` clears neither the lock nor the page contents. Only `tst_rst_n` clears them.
- R12: The offset is loaded from the address and moves forward with each page-write byte and each read byte. A later read with no address therefore continues where the last access stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous functional reset (sequencer, staging, offset) |
| tst_rst_n | input | 1 | Active-low asynchronous test reset; clears lock and page |
| cmd_start | input | 1 | Start strobe: a new command begins |
| cmd_is_idp | input | 1 | Command type targets the identification page |
| cmd_rd | input | 1 | Command direction: 1 read, 0 write |
| addr_valid | input | 1 | Both address bytes received |
| addr_in | input | 16 | Received address |
| wr_valid | input | 1 | Write data byte received |
| wr_data | input | 8 | Write data byte |
| wr_ack_valid | output | 1 | Acknowledge decision available |
| wr_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| stop_evt | input | 1 | Stop condition seen |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Engine accepts the read byte |
| rd_data | output | 8 | Read byte |

## Verification
The bench builds the block with its defaults: a 128-byte page, 16-bit addresses, the mode selected by bit 10 and the lock trigger in bit 1. With these values the wrap from offset 127 to 0 is reached on both the write path and the read path, and stray upper address bits near bit 10 are exercised. Random page writes, current and random reads, and foreign commands run against a bench-side model of the page, the offset and the lock. Directed sequences cover the lock with the trigger bit clear and then set, the status query with its Start/Stop abort, and the two resets.

// File: rtl/idp_pkg.sv
package idp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_READ = 2'd3
  } idp_state_e;
endpackage

// File: rtl/idp_lock_bit.sv
module idp_lock_bit (
  input  logic clk,
  input  logic tst_rst_n,
  input  logic lock_set,
  output logic locked
);
  logic lock_q;

  always_ff @(posedge clk or negedge tst_rst_n) begin
    if (!tst_rst_n) lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  // R6 / R11: once set, only test reset clears the lock
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!tst_rst_n)
    $past(lock_q) |-> lock_q);
endmodule

// File: rtl/idp_page_store.sv
module idp_page_store #(
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_rst_n,
  input  logic              stage_we,
  input  logic              stage_clr,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] din,
  input  logic              commit_page,
  input  logic              locked,
  output logic [DATA_W-1:0] dout
);
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic [DATA_W-1:0]     page_q  [PAGE_BYTES];
  logic [DATA_W-1:0]     stage_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = stage_we && (ofs == OFS_W'(g));

    always_ff @(posedge clk) begin
      if (hit) stage_q[g] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[g] <= 1'b0;
      else if (stage_clr) mask_q[g] <= 1'b0;
      else if (hit) mask_q[g] <= 1'b1;
    end

    always_ff @(posedge clk or negedge tst_rst_n) begin
      if (!tst_rst_n) page_q[g] <= ERASED;
      else if (commit_page && mask_q[g]) page_q[g] <= stage_q[g];
    end
  end

  assign dout = page_q[ofs];

  // R7: a locked page never receives a commit of staged bytes
  a_r7_no_commit_locked: assert property (@(posedge clk) disable iff (!rst_n || !tst_rst_n)
    locked |-> !(commit_page && (mask_q != '0)));
endmodule

// File: rtl/idp_seq.sv
module idp_seq
  import idp_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int OFS_W         = 7,
  parameter int LOCK_SEL_BIT  = 10,
  parameter int LOCK_DATA_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_is_idp,
  input  logic              cmd_rd,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_evt,
  input  logic              rd_ready,
  input  logic              locked,
  output logic              stage_we,
  output logic              stage_clr,
  output logic              commit_page,
  output logic              lock_set,
  output logic [OFS_W-1:0]  ptr,
  output logic              rd_valid,
  output logic              wr_ack_valid,
  output logic              wr_ack
);
  idp_state_e       state_q;
  logic [OFS_W-1:0] ptr_q;
  logic             lock_mode_q;
  logic             lock_pend_q;
  logic             last_data_q;
  logic             ack_v_q, ack_q;
  logic             in_data, byte_ok, commit;
  logic             unused_in_bits;

  assign unused_in_bits = ^{addr_in, wr_data};

  assign in_data = (state_q == ST_DATA);
  assign byte_ok = in_data && wr_valid && !cmd_start && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      lock_mode_q <= 1'b0;
      lock_pend_q <= 1'b0;
      last_data_q <= 1'b0;
    end else if (cmd_start) begin
      state_q     <= !cmd_is_idp ? ST_IDLE : (cmd_rd ? ST_READ : ST_ADDR);
      lock_pend_q <= 1'b0;
      last_data_q <= 1'b0;
    end else if (stop_evt) begin
      state_q     <= ST_IDLE;
      lock_pend_q <= 1'b0;
      last_data_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (addr_valid) begin
          ptr_q       <= addr_in[OFS_W-1:0];
          lock_mode_q <= addr_in[LOCK_SEL_BIT];
          state_q     <= ST_DATA;
        end
        ST_DATA: if (wr_valid) begin
          last_data_q <= 1'b1;
          if (lock_mode_q) lock_pend_q <= wr_data[LOCK_DATA_BIT];
          else             ptr_q       <= ptr_q + 1'b1;
        end
        ST_READ: if (rd_ready) ptr_q <= ptr_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_v_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_v_q <= byte_ok;
      ack_q   <= byte_ok && !locked;
    end
  end

  assign stage_we     = byte_ok && !lock_mode_q && !locked;
  assign stage_clr    = cmd_start || stop_evt;
  assign commit       = stop_evt && !cmd_start && in_data && last_data_q;
  assign commit_page  = commit && !lock_mode_q;
  assign lock_set     = commit && lock_mode_q && lock_pend_q;
  assign ptr          = ptr_q;
  assign rd_valid     = (state_q == ST_READ);
  assign wr_ack_valid = ack_v_q;
  assign wr_ack       = ack_q;

  // R8: an acknowledge decision only ever follows a received byte
  a_r8_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack_valid |-> $past(wr_valid));

  // R10: a foreign command yields neither a read stream nor an acknowledge
  a_r10_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_is_idp) |=> (!rd_valid && !wr_ack_valid));

  // R9: a stalled read keeps its offset
  a_r9_stall_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cmd_start && !stop_evt) |=> (rd_valid && $stable(ptr)));
endmodule

// File: rtl/idp_lock_ctrl.sv
module idp_lock_ctrl #(
  parameter int PAGE_BYTES    = 128,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int LOCK_SEL_BIT  = 10,
  parameter int LOCK_DATA_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_rst_n,
  input  logic              cmd_start,
  input  logic              cmd_is_idp,
  input  logic              cmd_rd,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack_valid,
  output logic              wr_ack,
  input  logic              stop_evt,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic             stage_we, stage_clr, commit_page, lock_set, locked;
  logic [OFS_W-1:0] ptr;

  idp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
    .LOCK_SEL_BIT(LOCK_SEL_BIT), .LOCK_DATA_BIT(LOCK_DATA_BIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_is_idp(cmd_is_idp), .cmd_rd(cmd_rd),
    .addr_valid(addr_valid), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .stop_evt(stop_evt), .rd_ready(rd_ready), .locked(locked),
    .stage_we(stage_we), .stage_clr(stage_clr), .commit_page(commit_page),
    .lock_set(lock_set), .ptr(ptr), .rd_valid(rd_valid),
    .wr_ack_valid(wr_ack_valid), .wr_ack(wr_ack)
  );

  idp_page_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .tst_rst_n(tst_rst_n),
    .stage_we(stage_we), .stage_clr(stage_clr), .ofs(ptr), .din(wr_data),
    .commit_page(commit_page), .locked(locked), .dout(rd_data)
  );

  idp_lock_bit u_lock (
    .clk(clk), .tst_rst_n(tst_rst_n), .lock_set(lock_set), .locked(locked)
  );

  // R9: the offered byte does not change while the engine stalls
  a_r9_stall_holds_data: assert property (@(posedge clk) disable iff (!rst_n || !tst_rst_n)
    (rd_valid && !rd_ready && !cmd_start && !stop_evt) |=> $stable(rd_data));
endmodule

// File: tb/tb_idp_lock_ctrl.sv
module tb_idp_lock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tst_rst_n = 1'b0;
  logic cmd_start = 0, cmd_is_idp = 0, cmd_rd = 0;
  logic addr_valid = 0, wr_valid = 0, stop_evt = 0, rd_ready = 0;
  logic [15:0] addr_in = '0;
  logic [7:0]  wr_data = '0;
  logic wr_ack_valid, wr_ack, rd_valid;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] mdl_mem [PAGE];
  bit         mdl_lock;
  int         mdl_ptr;
  bit         st_v [PAGE];
  logic [7:0] st_d [PAGE];

  always #(CLK_PERIOD/2) clk = ~clk;

  idp_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tst_rst_n(tst_rst_n),
    .cmd_start(cmd_start), .cmd_is_idp(cmd_is_idp), .cmd_rd(cmd_rd),
    .addr_valid(addr_valid), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ack_valid(wr_ack_valid), .wr_ack(wr_ack),
    .stop_evt(stop_evt), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_erase();
    for (int i = 0; i < PAGE; i++) mdl_mem[i] = 8'hFF;
    mdl_lock = 0;
  endfunction

  task automatic pulse_start(input bit idp, input bit rd);
    cmd_start = 1; cmd_is_idp = idp; cmd_rd = rd;
    @(negedge clk); cmd_start = 0;
  endtask

  task automatic send_addr(input logic [15:0] a);
    addr_valid = 1; addr_in = a;
    @(negedge clk); addr_valid = 0;
  endtask

  task automatic send_stop();
    stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask

  task automatic send_data(input logic [7:0] d, input bit exp_v, input bit exp_a, input string tag);
    wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
    chk(wr_ack_valid == exp_v, {tag, " ack_valid"}, wr_ack_valid, exp_v);
    if (exp_v) chk(wr_ack == exp_a, {tag, " ack"}, wr_ack, exp_a);
  endtask

  // endk: 0 = Stop after last byte, 1 = Start then Stop (abort)
  task automatic id_write(input bit idp, input logic [15:0] a, input int n, input int endk,
                          input bit fixed_en, input logic [7:0] fixed, input string tag);
    bit lm, pend;
    lm = a[10]; pend = 0;
    for (int i = 0; i < PAGE; i++) st_v[i] = 0;
    pulse_start(idp, 0);
    send_addr(a);
    if (idp) mdl_ptr = a[6:0];
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = fixed_en ? fixed : 8'($urandom);
      send_data(d, idp, !mdl_lock, tag);
      if (idp) begin
        if (lm) pend = d[1];
        else begin
          if (!mdl_lock) begin st_v[mdl_ptr] = 1; st_d[mdl_ptr] = d; end
          mdl_ptr = (mdl_ptr + 1) % PAGE;
        end
      end
    end
    if (endk == 1) pulse_start(1, 0);
    send_stop();
    if (endk == 0 && idp && n > 0) begin
      if (lm) begin if (pend) mdl_lock = 1; end
      else for (int i = 0; i < PAGE; i++) if (st_v[i]) mdl_mem[i] = st_d[i];
    end
  endtask

  task automatic read_bytes(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(rd_valid == 1, {tag, " rd_valid"}, rd_valid, 1);
      chk(rd_data == mdl_mem[mdl_ptr], {tag, " rd_data"}, rd_data, mdl_mem[mdl_ptr]);
      rd_ready = 1;
      @(negedge clk); rd_ready = 0;
      mdl_ptr = (mdl_ptr + 1) % PAGE;
    end
  endtask

  task automatic cur_read(input int n, input string tag);
    pulse_start(1, 1);
    read_bytes(n, tag);
    send_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    pulse_start(1, 0);
    send_addr(a);
    mdl_ptr = a[6:0];
    pulse_start(1, 1);
    read_bytes(n, tag);
    send_stop();
  endtask

  task automatic status_query(input string tag);
    id_write(1, 16'h0000, 1, 1, 1, 8'h00, tag);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    model_erase();
    mdl_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; tst_rst_n = 1;
    @(negedge clk);

    // R1: idle outputs and erased page
    chk(rd_valid == 0, "R1 rd_valid idle", rd_valid, 0);
    chk(wr_ack_valid == 0, "R1 ack idle", wr_ack_valid, 0);
    cur_read(4, "R1 erased");
    status_query("R1 unlocked");

    // R2: page write, upper bits (A7, A15..A11, A9..A8) ignored
    id_write(1, 16'hB18A, 3, 0, 0, 0, "R2 write");
    rand_read(16'h000A, 3, "R2 readback");

    // R3: write rolls over page end
    id_write(1, 16'hF37E, 5, 0, 0, 0, "R3 wrap write");
    rand_read(16'h007E, 5, "R3 wrap read");

    // R12: current read continues from the offset left by the write
    id_write(1, 16'h0020, 2, 0, 0, 0, "R12 write");
    cur_read(2, "R12 continue");

    // R4: abort by Start before Stop
    id_write(1, 16'h0040, 3, 1, 0, 0, "R4 abort");
    rand_read(16'h0040, 3, "R4 unchanged");

    // R5: Stop right after the address commits nothing
    id_write(1, 16'h0050, 0, 0, 0, 0, "R5 addr stop");
    rand_read(16'h0050, 1, "R5 unchanged");

    // R10: foreign write and foreign read are ignored
    id_write(0, 16'h0005, 2, 0, 0, 0, "R10 foreign write");
    pulse_start(0, 1);
    chk(rd_valid == 0, "R10 foreign read rd_valid", rd_valid, 0);
    send_stop();
    cur_read(1, "R10 ptr kept");
    rand_read(16'h0005, 2, "R10 unchanged");

    // R9: stall holds data, wrap at 127
    mdl_ptr = 16'h7F;
    pulse_start(1, 0); send_addr(16'h007F); pulse_start(1, 1);
    for (int k = 0; k < 3; k++) begin
      chk(rd_valid == 1, "R9 stall valid", rd_valid, 1);
      chk(rd_data == mdl_mem[8'h7F], "R9 stall data", rd_data, mdl_mem[8'h7F]);
      @(negedge clk);
    end
    read_bytes(3, "R9 wrap read");
    send_stop();

    // random mix
    for (int it = 0; it < 60; it++) begin
      int r;
      logic [15:0] a;
      r = $urandom % 4;
      a = 16'($urandom); a[10] = 1'b0;
      case (r)
        0: id_write(1, a, 1 + ($urandom % 6), $urandom % 2, 0, 0, "R2 rand write");
        1: cur_read(1 + ($urandom % 4), "R12 rand cur read");
        2: rand_read(a, 1 + ($urandom % 4), "R9 rand read");
        default: id_write(0, a, 1 + ($urandom % 3), 0, 0, 0, "R10 rand foreign");
      endcase
    end

    // R6: trigger bit clear does not lock
    id_write(1, 16'hE4F0, 1, 0, 1, 8'hFD, "R6 lock bit clear");
    status_query("R6 still unlocked");
    // R6: lock request aborted by Start does not lock
    id_write(1, 16'h0400, 1, 1, 1, 8'h02, "R6 lock aborted");
    status_query("R6 unlocked after abort");
    id_write(1, 16'h0400, 1, 0, 1, 8'h02, "R6 lock set");
    status_query("R8 locked nack");

    // R7: locked page write is not acknowledged and changes nothing
    id_write(1, 16'h0010, 4, 0, 0, 0, "R7 locked write");
    rand_read(16'h0010, 4, "R7 unchanged");

    // R11: functional reset keeps lock and page
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    mdl_ptr = 0;
    chk(rd_valid == 0, "R1 rd_valid after rst", rd_valid, 0);
    cur_read(3, "R11 page kept");
    status_query("R11 lock kept");

    // R11 / R1: test reset clears lock and page
    @(negedge clk); rst_n = 0; tst_rst_n = 0; @(negedge clk);
    rst_n = 1; tst_rst_n = 1; @(negedge clk);
    model_erase(); mdl_ptr = 0;
    status_query("R11 unlocked after test reset");
    rand_read(16'h0000, 4, "R1 erased after test reset");

    finish_run();
  end
endmodule